// File: doc/BRIEF.md
# SMBus Memory Target

This block is a two-wire serial bus target holding a 256-byte byte-addressed array. It watches the open-drain clock and data lines, and it takes part in the bus only by pulling the data line low. A master reaches the array through the ordinary SMBus frame shapes: quick command, send byte, receive byte, and writes or reads that carry a command byte.

An internal 8-bit location pointer serves the streaming reads. A lone written byte, or the command byte that comes before a repeated start into a read, loads the pointer. Each byte sent back to the master advances the pointer. A write that carries a command byte puts its payload at consecutive locations, starting at the command value. It wraps through the full array, and no length byte is expected. Several copies can sit on one bus: each copy has its own 7-bit address, set by a parameter, and its own array. A host-side backdoor port lets the array be preloaded and inspected without using the bus.

Both bus lines pass through a synchronizer and a glitch filter before start and stop conditions are decoded.

Top module: `smbmem_target`

## Requirements
- R1: After reset the location pointer is 0x00 and the data line is released (`sda_oe` = 0). A receive-byte as the first bus access returns the byte at location 0x00.
- R2: The target acknowledges only an address byte whose upper seven bits equal `DEV_ADDR`. Bit 0 of the address byte is the direction (1 = read). Any other address is not acknowledged, and the rest of that frame has no effect.
- R3: A write frame that ends (by stop or repeated start) after exactly one data byte loads that byte into the location pointer. It writes nothing into the array.
- R4: A receive-byte returns the array byte at the pointer, then adds one to the pointer. The pointer wraps from 0xFF to 0x00.
- R5: In a write frame with two or more data bytes, the first byte is the command C. Payload byte k (k from 0) is stored at location (C+k) mod 256. The location pointer is not changed.
- R6: A read with a command byte (write C, repeated start, read) returns bytes from C, C+1, ... modulo 256. Afterwards the pointer is one past the last byte returned.
- R7: A quick command (address with direction 0, then stop) is acknowledged. It changes neither the pointer nor the array.
- R8: Every data byte written to a selected target is acknowledged. A master NACK after a read byte makes the target release the data line and go idle. A stop always returns it to idle with the line released.
- R9: The target asserts its data-line drive only while the filtered clock line is low.
- R10: A backdoor write stores `bd_wdata` at `bd_addr` on that clock edge. A backdoor read presents the addressed byte on `bd_rdata` one clock later.
- R11: A pulse on either bus line shorter than `FILT_LEN` clock cycles is ignored. A clock glitch during a bit does not add a bit, and a data glitch while the clock is high does not form a start or stop.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level of the bus clock line |
| sda_i | input | 1 | Level of the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| bd_we | input | 1 | Backdoor write strobe |
| bd_addr | input | 8 | Backdoor array location |
| bd_wdata | input | 8 | Backdoor write byte |
| bd_rdata | output | 8 | Backdoor read byte, one cycle after `bd_addr` |

## Verification
A corrupted location pointer shows up in the very next receive-byte or read-with-command frame as a wrong byte on the data line. Every later streamed byte is then wrong too, because the error carries forward through the increments. A bad write address or a bad wrap lands payload in the wrong array cells, and the backdoor read port shows that one clock after it is addressed. An error in the bit sequencer or the filter shows within a single byte time: an acknowledge goes missing, the data comes back shifted, or the data line is driven while the clock is high.

// File: rtl/smbmem_pkg.sv
package smbmem_pkg;

    localparam int BYTE_W     = 8;
    localparam int MEM_DEPTH  = 256;
    localparam int PTR_W      = $clog2(MEM_DEPTH);
    localparam int BITCNT_W   = $clog2(BYTE_W);
    localparam int WRCNT_W    = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } link_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic  en;
        ptr_t  addr;
        byte_t data;
    } mem_wr_t;

    function automatic ptr_t ptr_step(input ptr_t p);
        return p + ptr_t'(1);
    endfunction

endpackage

// File: rtl/smbmem_line_filter.sv
module smbmem_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   filt_q;
    logic                   sync_out;

    assign sync_out = sync_q[SYNC_STAGES-1];
    assign line_o   = filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            if (sync_out != filt_q) begin
                if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
                    filt_q <= sync_out;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (rst)
        (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_out))); // R11

endmodule

// File: rtl/smbmem_bus_events.sv
module smbmem_bus_events
    import smbmem_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.scl   = scl_f;
        ev.sda   = sda_f;
        ev.rise  = scl_f & ~scl_q;
        ev.fall  = ~scl_f & scl_q;
        ev.start = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop  = scl_f & scl_q & ~sda_q & sda_f;
    end

endmodule

// File: rtl/smbmem_array.sv
module smbmem_array
    import smbmem_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ptr_t    rd_addr,
    output byte_t   rd_data,
    input  mem_wr_t bus_wr,
    input  logic    bd_we,
    input  ptr_t    bd_addr,
    input  byte_t   bd_wdata,
    output byte_t   bd_rdata
);
    byte_t arr [MEM_DEPTH];
    logic  bus_blocked;

    assign bus_blocked = bd_we && (bd_addr == bus_wr.addr);
    assign rd_data     = arr[rd_addr];

    always_ff @(posedge clk) begin
        if (bus_wr.en && !bus_blocked) begin
            arr[bus_wr.addr] <= bus_wr.data;
        end
        if (bd_we) begin
            arr[bd_addr] <= bd_wdata;
        end
        bd_rdata <= arr[bd_addr];
    end

    AST_BD_STORE: assert property (@(posedge clk) disable iff (rst)
        bd_we |=> (arr[$past(bd_addr)] == $past(bd_wdata))); // R10

endmodule

// File: rtl/smbmem_link_fsm.sv
module smbmem_link_fsm
    import smbmem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  byte_t   mem_rdata,
    output ptr_t    ptr,
    output mem_wr_t mem_wr,
    output logic    sda_oe
);
    link_state_e           state_q;
    logic [BITCNT_W-1:0]   bitcnt_q;
    byte_t                 shreg_q;
    ptr_t                  ptr_q;
    ptr_t                  waddr_q;
    logic [WRCNT_W-1:0]    wrcnt_q;
    logic                  rx_full_q;
    logic                  is_addr_q;
    logic                  rd_q;
    logic                  oe_q;
    logic                  seg_load;
    logic                  byte_in;

    assign ptr      = ptr_q;
    assign sda_oe   = oe_q;
    assign seg_load = (ev.start || ev.stop) && (wrcnt_q == WRCNT_W'(1));
    assign byte_in  = (state_q == ST_RX) && ev.fall && rx_full_q;

    always_comb begin
        mem_wr.en   = byte_in && !is_addr_q && (wrcnt_q != '0);
        mem_wr.addr = waddr_q;
        mem_wr.data = shreg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            bitcnt_q  <= '0;
            shreg_q   <= '0;
            ptr_q     <= '0;
            waddr_q   <= '0;
            wrcnt_q   <= '0;
            rx_full_q <= 1'b0;
            is_addr_q <= 1'b0;
            rd_q      <= 1'b0;
            oe_q      <= 1'b0;
        end else if (ev.start) begin
            if (seg_load) ptr_q <= waddr_q;
            state_q   <= ST_RX;
            is_addr_q <= 1'b1;
            bitcnt_q  <= '0;
            rx_full_q <= 1'b0;
            wrcnt_q   <= '0;
            oe_q      <= 1'b0;
        end else if (ev.stop) begin
            if (seg_load) ptr_q <= waddr_q;
            state_q   <= ST_IDLE;
            wrcnt_q   <= '0;
            oe_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RX: begin
                    if (ev.rise) begin
                        shreg_q  <= {shreg_q[BYTE_W-2:0], ev.sda};
                        bitcnt_q <= bitcnt_q + BITCNT_W'(1);
                        if (bitcnt_q == BITCNT_W'(BYTE_W - 1)) rx_full_q <= 1'b1;
                    end else if (byte_in) begin
                        rx_full_q <= 1'b0;
                        if (is_addr_q) begin
                            if (shreg_q[BYTE_W-1:1] == DEV_ADDR) begin
                                oe_q      <= 1'b1;
                                rd_q      <= shreg_q[0];
                                is_addr_q <= 1'b0;
                                state_q   <= ST_ACK;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            oe_q    <= 1'b1;
                            state_q <= ST_ACK;
                            if (wrcnt_q == '0) waddr_q <= shreg_q;
                            else               waddr_q <= ptr_step(waddr_q);
                            if (wrcnt_q != WRCNT_W'(2)) wrcnt_q <= wrcnt_q + WRCNT_W'(1);
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        bitcnt_q <= '0;
                        if (rd_q) begin
                            shreg_q <= mem_rdata;
                            oe_q    <= ~mem_rdata[BYTE_W-1];
                            state_q <= ST_TX;
                        end else begin
                            oe_q    <= 1'b0;
                            state_q <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.fall) begin
                        bitcnt_q <= bitcnt_q + BITCNT_W'(1);
                        if (bitcnt_q == BITCNT_W'(BYTE_W - 1)) begin
                            oe_q    <= 1'b0;
                            ptr_q   <= ptr_step(ptr_q);
                            state_q <= ST_RACK;
                        end else begin
                            oe_q    <= ~shreg_q[BYTE_W-2];
                            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.rise) begin
                        state_q <= ev.sda ? ST_IDLE : ST_ACK;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> !ev.scl); // R9
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !oe_q); // R8
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state_q == ST_IDLE)); // R8
    AST_NACK_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_RACK) && ev.rise && ev.sda) |=> (state_q == ST_IDLE && !oe_q)); // R8
    AST_PTR_STEP_OR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ptr_q != $past(ptr_q)) |-> ((ptr_q == ptr_step($past(ptr_q))) || $past(seg_load))); // R4
    AST_WRITE_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        mem_wr.en |=> (ptr_q == $past(ptr_q))); // R5

endmodule

// File: rtl/smbmem_target.sv
module smbmem_target
    import smbmem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       bd_we,
    input  logic [7:0] bd_addr,
    input  logic [7:0] bd_wdata,
    output logic [7:0] bd_rdata
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    bus_ev_t            ev;
    ptr_t               ptr;
    byte_t              mem_rdata;
    mem_wr_t            mem_wr;

    assign raw_lines = {scl_i, sda_i};

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        smbmem_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw_lines[i]),
            .line_o (filt_lines[i])
        );
    end

    smbmem_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_f (filt_lines[1]),
        .sda_f (filt_lines[0]),
        .ev    (ev)
    );

    smbmem_link_fsm #(
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .mem_rdata (mem_rdata),
        .ptr       (ptr),
        .mem_wr    (mem_wr),
        .sda_oe    (sda_oe)
    );

    smbmem_array u_array (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (ptr),
        .rd_data  (mem_rdata),
        .bus_wr   (mem_wr),
        .bd_we    (bd_we),
        .bd_addr  (bd_addr),
        .bd_wdata (bd_wdata),
        .bd_rdata (bd_rdata)
    );

endmodule

// File: tb/smbmem_target_bench.sv
`timescale 1ns/1ps
module smbmem_target_bench;
    localparam int T = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic oe_a, oe_b;
    logic sda_bus;
    assign sda_bus = m_sda & ~oe_a & ~oe_b;

    logic       bwe_a = 1'b0, bwe_b = 1'b0;
    logic [7:0] bad_a = '0, bwd_a = '0, bad_b = '0, bwd_b = '0;
    logic [7:0] brd_a, brd_b;

    smbmem_target #(.DEV_ADDR(7'h50)) u_smbmem_target (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(oe_a),
        .bd_we(bwe_a), .bd_addr(bad_a), .bd_wdata(bwd_a), .bd_rdata(brd_a));

    smbmem_target #(.DEV_ADDR(7'h51)) u_smbmem_target_b (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(oe_b),
        .bd_we(bwe_b), .bd_addr(bad_b), .bd_wdata(bwd_b), .bd_rdata(brd_b));

    int         vectors = 0;
    int         misses  = 0;
    logic [7:0] ref_a [256];
    logic [7:0] ref_b [256];
    logic [7:0] ref_ptr;

    function automatic logic [7:0] loc(input logic [7:0] base, input int k);
        return base + k[7:0];
    endfunction

    function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
        return {a, rd};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b, input int g, output logic s);
        repeat (T) @(negedge clk); m_sda = b;
        repeat (T) @(negedge clk); m_scl = 1'b1;
        repeat (T/2) @(negedge clk);
        if (g == 1) begin m_scl = 1'b0; @(negedge clk); m_scl = 1'b1; end
        else if (g == 2) begin m_sda = 1'b0; @(negedge clk); m_sda = b; end
        repeat (T/2) @(negedge clk); s = sda_bus;
        repeat (T) @(negedge clk); m_scl = 1'b0;
    endtask

    task automatic do_start();
        repeat (T) @(negedge clk); m_sda = 1'b1;
        repeat (T) @(negedge clk); m_scl = 1'b1;
        repeat (T) @(negedge clk); m_sda = 1'b0;
        repeat (T) @(negedge clk); m_scl = 1'b0;
    endtask

    task automatic do_stop();
        repeat (T) @(negedge clk); m_sda = 1'b0;
        repeat (T) @(negedge clk); m_scl = 1'b1;
        repeat (T) @(negedge clk); m_sda = 1'b1;
        repeat (T) @(negedge clk);
    endtask

    task automatic wbyte(input logic [7:0] v, input int g, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], (i == 3) ? g : 0, s);
        clk_bit(1'b1, 0, s);
        ack = ~s;
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, 0, s); v[i] = s; end
        clk_bit(~mack, 0, s);
    endtask

    task automatic bd_read(input logic inst_b, input logic [7:0] a, output logic [7:0] d);
        if (inst_b) bad_b = a; else bad_a = a;
        @(negedge clk);
        d = inst_b ? brd_b : brd_a;
    endtask

    task automatic txn_send(input logic [7:0] v);
        logic ack;
        do_start();
        wbyte(addr_byte(7'h50, 1'b0), 0, ack); chk("R2 addr ack", ack, 1);
        wbyte(v, 0, ack);                      chk("R8 data ack", ack, 1);
        do_stop();
        ref_ptr = v;
    endtask

    task automatic txn_recv();
        logic ack; logic [7:0] d;
        do_start();
        wbyte(addr_byte(7'h50, 1'b1), 0, ack); chk("R2 addr ack", ack, 1);
        rbyte(1'b0, d);
        do_stop();
        chk("R4 receive byte", d, ref_a[ref_ptr]);
        chk("R8 released after nack", oe_a, 0);
        ref_ptr = ref_ptr + 8'd1;
    endtask

    task automatic txn_wcmd(input logic [7:0] c, input int n);
        logic ack; logic [7:0] d;
        do_start();
        wbyte(addr_byte(7'h50, 1'b0), 0, ack); chk("R2 addr ack", ack, 1);
        wbyte(c, 0, ack);                      chk("R8 cmd ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            wbyte(d, 0, ack); chk("R8 payload ack", ack, 1);
            ref_a[loc(c, k)] = d;
        end
        do_stop();
    endtask

    task automatic txn_rcmd(input logic [7:0] c, input int n);
        logic ack; logic [7:0] d;
        do_start();
        wbyte(addr_byte(7'h50, 1'b0), 0, ack); chk("R2 addr ack", ack, 1);
        wbyte(c, 0, ack);                      chk("R8 cmd ack", ack, 1);
        do_start();
        wbyte(addr_byte(7'h50, 1'b1), 0, ack); chk("R2 addr ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            rbyte(k != n - 1, d);
            chk("R6 command read", d, ref_a[loc(c, k)]);
        end
        do_stop();
        ref_ptr = loc(c, n);
    endtask

    task automatic txn_quick();
        logic ack;
        do_start();
        wbyte(addr_byte(7'h50, 1'b0), 0, ack); chk("R7 quick ack", ack, 1);
        do_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        misses++;
        $display("FAIL R8 watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       ack;
        void'($urandom(32'd2024));
        repeat (6) @(negedge clk);
        chk("R1 reset release a", oe_a, 0);
        chk("R1 reset release b", oe_b, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        for (int a = 0; a < 256; a++) begin
            bwe_a = 1'b1; bad_a = 8'(a); bwd_a = 8'($urandom); ref_a[a] = bwd_a;
            bwe_b = 1'b1; bad_b = 8'(a); bwd_b = 8'($urandom); ref_b[a] = bwd_b;
            @(negedge clk);
        end
        bwe_a = 1'b0; bwe_b = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] a;
            a = 8'($urandom);
            bd_read(1'b0, a, d); chk("R10 backdoor read", d, ref_a[a]);
        end

        ref_ptr = 8'h00;
        txn_recv();                                  // R1: first read at 0x00
        txn_send(8'hFE);                             // R3
        bd_read(1'b0, 8'hFE, d); chk("R3 no array write", d, ref_a[8'hFE]);
        txn_recv(); txn_recv(); txn_recv();          // R4 wrap FE FF 00
        chk("R4 pointer wrapped", ref_ptr, 8'h01);
        txn_wcmd(8'hFD, 5);                          // R5 wrap through FF
        for (int k = 0; k < 5; k++) begin
            bd_read(1'b0, loc(8'hFD, k), d); chk("R5 wrapped payload", d, ref_a[loc(8'hFD, k)]);
        end
        txn_recv();                                  // R5 pointer kept at 0x01
        txn_rcmd(8'h40, 4);                          // R6
        txn_recv();                                  // R6 continues at 0x44
        txn_quick();                                 // R7
        txn_recv();                                  // R7 pointer unchanged

        do_start();
        wbyte(addr_byte(7'h52, 1'b0), 0, ack); chk("R2 foreign nack", ack, 0);
        wbyte(8'h10, 0, ack);                  chk("R2 foreign data ignored", ack, 0);
        do_stop();
        txn_recv();                                  // R2 pointer unaffected

        do_start();
        wbyte(addr_byte(7'h51, 1'b0), 0, ack); chk("R2 second target ack", ack, 1);
        wbyte(8'h10, 0, ack);
        wbyte(8'h77, 0, ack);
        do_stop();
        ref_b[8'h10] = 8'h77;
        bd_read(1'b1, 8'h10, d); chk("R2 second target stored", d, 8'h77);
        bd_read(1'b0, 8'h10, d); chk("R2 first target untouched", d, ref_a[8'h10]);

        do_start();
        wbyte(addr_byte(7'h50, 1'b0), 0, ack);
        wbyte(8'h20, 0, ack);
        wbyte(8'h5A, 1, ack); chk("R11 scl glitch ack", ack, 1);
        wbyte(8'hC9, 2, ack); chk("R11 sda glitch ack", ack, 1);
        do_stop();
        ref_a[8'h20] = 8'h5A; ref_a[8'h21] = 8'hC9;
        bd_read(1'b0, 8'h20, d); chk("R11 scl glitch data", d, 8'h5A);
        bd_read(1'b0, 8'h21, d); chk("R11 sda glitch data", d, 8'hC9);

        for (int t = 0; t < 25; t++) begin
            case ($urandom_range(0, 4))
                0: txn_send(8'($urandom));
                1: txn_recv();
                2: txn_wcmd(8'($urandom), $urandom_range(1, 4));
                3: txn_rcmd(8'($urandom), $urandom_range(1, 4));
                default: txn_quick();
            endcase
        end
        txn_recv();
        chk("R8 final release", oe_a, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule